// File: doc/BRIEF.md
# Multistage Programmable-Delay Timeslot Interchanger

This block reorders the timeslots of one input port inside a fixed-length frame of `T_SLOTS` slots, and holds the latency from frame start to frame start constant. One slot arrives per clock cycle. A slot is a data word plus a valid bit. Words pass through a chain of delay stages. Each stage has `W_PATHS` fixed delay lines, and a per-slot selection steers each word into exactly one line. Path `j` of a stage delays by `j` times that stage's unit. The units are the powers of the radix `n = floor((W_PATHS+1)/2)`, rising and then falling again, so the chain forms a radix-`n` rearrangeable network in time. Any permutation of a frame can be realised once a routing pass has produced the selections.

The block does not compute the selections. Software or a scheduler writes them through a configuration port. Each write carries one slot index and one selection per stage. The writes land in a shadow table. The first slot of a frame snapshots that table as it enters, and each later stage adopts the frame's settings at the moment that frame's first slot reaches it. Words already in flight therefore keep the routing they were given. A collision output marks any cycle in which two words try to leave one stage together.

Top module: `slot_interchanger`

## Requirements
- R1: The radix is n = floor((W_PATHS+1)/2) and the chain has 2·ceil(log_n T_SLOTS) − 1 stages. In stage i, path j delays a word by j·u_i cycles. The unit u_i is n^i over the first half of the chain and mirrors back down over the second half (for the defaults the units are 1, 3, 1). A full reversal of the frame uses the shortest path (0) and the longest path (4) and still emerges intact.
- R2: When every stage selects its base path n−1 (value 2 by default), the frame comes out in its original order. Slot q of input frame k then appears at cycle k·T + L + q, where L = T + T/n − 2 (10 for the defaults). Cycle 0 is the first cycle after reset release.
- R3: In general, a word entering at cycle c leaves at c + Σ j_i·u_i, where j_i is the path chosen in stage i. Stage i indexes its selection by the frame-relative slot position at which the word arrives at that stage. The selection bus carries stage i's value in bits [i·SEL_W +: SEL_W].
- R4: Frames can follow each other back to back with a different permutation in every frame, and no words mix between frames.
- R5: A configuration write goes into the shadow table. The snapshot for frame k is taken in the last slot cycle of frame k−1, and a write made in that same cycle is included. No later write alters a frame that has already begun entering.
- R6: A selection value of W_PATHS or more drops that word. The word never reaches the output, and the other words of the frame are unaffected.
- R7: `collision` is high in any cycle in which two or more delay lines of one stage emit a word. The word from the lowest-numbered path is forwarded.
- R8: Reset empties every delay line, holds `out_valid` and `collision` low, clears the shadow and active tables, and aligns the stage slot counters so that input slot 0 falls in the first cycle after release.
- R9: The block never emits more words than it has accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timeslot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input slot carries a word |
| in_data | input | DATA_W | Input word |
| cfg_we | input | 1 | Write one slot's selections into the shadow table |
| cfg_slot | input | SLOT_W | Slot index being written |
| cfg_sel | input | S_STAGES·SEL_W | Path selection for each stage, stage i in bits [i·SEL_W +: SEL_W] |
| out_valid | output | 1 | Output slot carries a word |
| out_data | output | DATA_W | Output word |
| collision | output | 1 | Two or more words met at a stage output this cycle |

## Verification
Two things can happen in the same clock cycle: a frame boundary, and a configuration write for the following frame. The bench writes the last slot's selections in exactly the cycle in which the snapshot is taken, while the previous frame's words are still travelling through later stages. It also changes the permutation in every frame. Correct handling shows up as every word arriving at the output slot that its own frame's selections predict. The collision flag is provoked separately, by steering two adjacent slots of an otherwise idle frame into the same stage-0 output cycle, and is judged in that one cycle.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    // Crossbar radix obtained from the number of selectable paths
    function automatic int radix_of(input int paths);
        return (paths + 1) / 2;
    endfunction

    // Number of radix digits needed to index a frame
    function automatic int digits_of(input int slots, input int radix);
        int span;
        int d;
        span = 1;
        d = 0;
        while (span < slots) begin
            span = span * radix;
            d++;
        end
        return d;
    endfunction

    // Delay unit of a stage: rising powers, then mirrored
    function automatic int unit_of(input int stage, input int radix, input int digits);
        int e;
        int u;
        e = (stage < digits) ? stage : (2 * digits - 2 - stage);
        u = 1;
        for (int i = 0; i < e; i++) u = u * radix;
        return u;
    endfunction

    // Cycle at which a stage's input frame starts, relative to input slot 0
    function automatic int offset_of(input int stage, input int radix, input int digits);
        int acc;
        acc = 0;
        for (int k = 0; k < stage; k++) acc += unit_of(k, radix, digits) * (radix - 1);
        return acc;
    endfunction

endpackage

// File: rtl/slot_delay_line.sv
module slot_delay_line #(
    parameter int DEPTH  = 1,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][DATA_W-1:0] dat;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        for (int i = 0; i < DEPTH - 1; i++) begin
            line_d.vld[i] = line_q.vld[i+1];
            line_d.dat[i] = line_q.dat[i+1];
        end
        line_d.vld[DEPTH-1] = in_valid;
        line_d.dat[DEPTH-1] = in_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign out_valid = line_q.vld[0];
    assign out_data  = line_q.dat[0];

endmodule

// File: rtl/slot_delay_stage.sv
module slot_delay_stage #(
    parameter int W_PATHS = 5,
    parameter int UNIT    = 1,
    parameter int DATA_W  = 8,
    parameter int SEL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [SEL_W-1:0]  sel,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              collide
);

    logic [W_PATHS-1:0]             lv;
    logic [W_PATHS-1:0][DATA_W-1:0] ld;

    for (genvar j = 0; j < W_PATHS; j++) begin : g_path
        if (j == 0) begin : g_direct
            assign lv[j] = in_valid && (sel == SEL_W'(j));
            assign ld[j] = in_data;
        end else begin : g_delayed
            slot_delay_line #(
                .DEPTH (j * UNIT),
                .DATA_W(DATA_W)
            ) u_line (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_valid (in_valid && (sel == SEL_W'(j))),
                .in_data  (in_data),
                .out_valid(lv[j]),
                .out_data (ld[j])
            );
        end
    end

    // Lowest-numbered path wins the output mux
    always_comb begin
        out_data = '0;
        for (int j = W_PATHS - 1; j >= 0; j--) begin
            if (lv[j]) out_data = ld[j];
        end
        out_valid = |lv;
        collide   = (lv & (lv - 1'b1)) != '0;
    end

endmodule

// File: rtl/slot_interchanger.sv
module slot_interchanger import tsi_pkg::*; #(
    parameter  int T_SLOTS  = 9,
    parameter  int W_PATHS  = 5,
    parameter  int DATA_W   = 8,
    localparam int N_RADIX  = radix_of(W_PATHS),
    localparam int M_DIG    = digits_of(T_SLOTS, N_RADIX),
    localparam int S_STAGES = 2 * M_DIG - 1,
    localparam int SEL_W    = $clog2(W_PATHS),
    localparam int SLOT_W   = $clog2(T_SLOTS),
    localparam int CFG_W    = S_STAGES * SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [CFG_W-1:0]  cfg_sel,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              collision
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(T_SLOTS - 1);

    typedef struct packed {
        logic [S_STAGES-1:0][SLOT_W-1:0]             slot;
        logic [T_SLOTS-1:0][CFG_W-1:0]               shadow;
        logic [S_STAGES-1:0][T_SLOTS-1:0][CFG_W-1:0] active;
    } ctl_t;

    function automatic ctl_t reset_value();
        ctl_t r;
        r = '0;
        for (int l = 0; l < S_STAGES; l++) begin
            r.slot[l] = SLOT_W'((T_SLOTS - offset_of(l, N_RADIX, M_DIG) % T_SLOTS) % T_SLOTS);
        end
        return r;
    endfunction

    localparam ctl_t CTL_RST = reset_value();

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        for (int l = 0; l < S_STAGES; l++) begin
            ctl_d.slot[l] = (ctl_q.slot[l] == LAST) ? '0 : ctl_q.slot[l] + 1'b1;
        end
        if (cfg_we && (int'(cfg_slot) < T_SLOTS)) ctl_d.shadow[cfg_slot] = cfg_sel;
        // Frame handoff: stage 0 snapshots the shadow (including this cycle's write),
        // each later stage inherits from its predecessor at its own boundary
        if (ctl_q.slot[0] == LAST) ctl_d.active[0] = ctl_d.shadow;
        for (int l = 1; l < S_STAGES; l++) begin
            if (ctl_q.slot[l] == LAST) ctl_d.active[l] = ctl_q.active[l-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    logic [S_STAGES:0]             st_v;
    logic [S_STAGES:0][DATA_W-1:0] st_d;
    logic [S_STAGES-1:0]           st_col;

    assign st_v[0] = in_valid;
    assign st_d[0] = in_data;

    for (genvar l = 0; l < S_STAGES; l++) begin : g_stage
        logic [SEL_W-1:0] sel_now;
        assign sel_now = ctl_q.active[l][ctl_q.slot[l]][l*SEL_W +: SEL_W];

        slot_delay_stage #(
            .W_PATHS(W_PATHS),
            .UNIT   (unit_of(l, N_RADIX, M_DIG)),
            .DATA_W (DATA_W),
            .SEL_W  (SEL_W)
        ) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (st_v[l]),
            .in_data  (st_d[l]),
            .sel      (sel_now),
            .out_valid(st_v[l+1]),
            .out_data (st_d[l+1]),
            .collide  (st_col[l])
        );
    end

    assign out_valid = st_v[S_STAGES];
    assign out_data  = st_d[S_STAGES];
    assign collision = |st_col;

    // Observation points for the bound checker
    logic [S_STAGES-1:0][SLOT_W-1:0]  slot_now;
    logic [T_SLOTS-1:0][CFG_W-1:0]    row_first;
    logic [T_SLOTS-1:0][CFG_W-1:0]    row_last;
    assign slot_now  = ctl_q.slot;
    assign row_first = ctl_q.active[0];
    assign row_last  = ctl_q.active[S_STAGES-1];

endmodule

// File: rtl/slot_interchanger_chk.sv
module slot_interchanger_chk import tsi_pkg::*; #(
    parameter int T_SLOTS  = 9,
    parameter int N_RADIX  = 3,
    parameter int M_DIG    = 2,
    parameter int S_STAGES = 3,
    parameter int SLOT_W   = 4,
    parameter int ROW_W    = 81
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             in_valid,
    input logic                             out_valid,
    input logic                             collision,
    input logic [S_STAGES-1:0][SLOT_W-1:0]  slot_now,
    input logic [ROW_W-1:0]                 row_first,
    input logic [ROW_W-1:0]                 row_last
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(T_SLOTS - 1);

    logic [31:0] in_cnt, out_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cnt  <= '0;
            out_cnt <= '0;
        end else begin
            in_cnt  <= in_cnt + 32'(in_valid);
            out_cnt <= out_cnt + 32'(out_valid);
        end
    end

    // R8: every stage counter keeps its fixed offset from the input counter
    for (genvar l = 1; l < S_STAGES; l++) begin : g_align
        localparam int OFF = offset_of(l, N_RADIX, M_DIG) % T_SLOTS;
        p_slot_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
            int'(slot_now[l]) == (int'(slot_now[0]) + T_SLOTS - OFF) % T_SLOTS);
    end

    // R5: active settings only change right after a frame's last slot
    p_cfg_hold_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_now[0] != LAST) |=> $stable(row_first));
    p_cfg_hold_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_now[S_STAGES-1] != LAST) |=> $stable(row_last));

    // R9: no word is created
    p_no_creation_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_cnt <= in_cnt);

    // R7: a collision needs at least two words in flight
    p_collision_words_r7: assert property (@(posedge clk) disable iff (!rst_n)
        collision |-> (in_cnt + 32'(in_valid) - out_cnt >= 32'd2));

endmodule

bind slot_interchanger slot_interchanger_chk #(
    .T_SLOTS (T_SLOTS),
    .N_RADIX (N_RADIX),
    .M_DIG   (M_DIG),
    .S_STAGES(S_STAGES),
    .SLOT_W  (SLOT_W),
    .ROW_W   (T_SLOTS * CFG_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .collision(collision),
    .slot_now (slot_now),
    .row_first(row_first),
    .row_last (row_last)
);

// File: tb/tb_slot_interchanger.sv
module tb_slot_interchanger;

    localparam int T   = 9;
    localparam int W   = 5;
    localparam int DW  = 8;
    localparam int LAT = 10;
    localparam int NF  = 34;
    localparam int NC  = NF * T + 40;
    localparam int COL_FRAME = 25;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          in_valid;
    logic [DW-1:0] in_data;
    logic          cfg_we;
    logic [3:0]    cfg_slot;
    logic [8:0]    cfg_sel;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          collision;

    slot_interchanger #(.T_SLOTS(T), .W_PATHS(W), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_sel(cfg_sel),
        .out_valid(out_valid), .out_data(out_data), .collision(collision)
    );

    logic [8:0]    cfg_mem [NF+1][T];
    logic          fv      [NF][T];
    logic [DW-1:0] fd      [NF][T];
    int            kind    [NF];
    logic          ev      [NC];
    logic [DW-1:0] ed      [NC];

    int n_chk  = 0;
    int n_fail = 0;
    int n_in   = 0;
    int n_out  = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic int perm3(input int idx, input int x);
        case (idx)
            0: return x;
            1: return 2 - x;
            2: return (x + 1) % 3;
            3: return (x + 2) % 3;
            4: return (x == 2) ? 2 : 1 - x;
            default: return (x == 0) ? 0 : 3 - x;
        endcase
    endfunction

    // kinds: 0 idle, 1 identity, 2 reversal, 3 random, 4 one dropped slot, 5 collision
    task automatic build(input int k, input int kd);
        int s0[3];
        int s1[3];
        int s2[3];
        for (int i = 0; i < 3; i++) begin
            s0[i] = 0; s1[i] = 0; s2[i] = 0;
            if (kd == 2) begin s0[i] = 1; s1[i] = 1; end
            if (kd == 3 || kd == 4) begin
                s0[i] = int'($urandom % 6); s1[i] = int'($urandom % 6); s2[i] = int'($urandom % 6);
            end
        end
        kind[k] = kd;
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                int p, b1, p1, a2, p2, b3, q;
                p  = 3 * a + b;
                b1 = perm3(s0[a], b);
                p1 = 3 * a + b1;
                a2 = perm3(s1[b1], a);
                p2 = 3 * a2 + b1;
                b3 = perm3(s2[a2], b1);
                q  = 3 * a2 + b3;
                cfg_mem[k][p][2:0]  = 3'(2 + b1 - b);
                cfg_mem[k][p1][5:3] = 3'(2 + a2 - a);
                cfg_mem[k][p2][8:6] = 3'(2 + b3 - b1);
                fd[k][p] = DW'($urandom);
                fv[k][p] = (kd >= 1 && kd <= 4);
                if (kd == 4 && p == 4) cfg_mem[k][p][2:0] = 3'd7;
                else if (fv[k][p]) begin
                    ev[k*T + LAT + q] = 1'b1;
                    ed[k*T + LAT + q] = fd[k][p];
                end
            end
        end
        if (kd == 5) begin
            cfg_mem[k][0][2:0] = 3'd1;
            cfg_mem[k][1][2:0] = 3'd0;
            fv[k][0] = 1'b1;
            fv[k][1] = 1'b1;
        end
    endtask

    function automatic string tag_of(input int c);
        int kf;
        if (c < LAT) return "R8 quiet";
        kf = (c - LAT) / T;
        if (kf >= NF) return "R4 flush";
        case (kind[kf])
            1: return "R2 in-order";
            2: return "R1/R3 reversal";
            3: return "R3/R4/R5 random";
            4: return "R6 dropped";
            default: return "R4 idle";
        endcase
    endfunction

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'h1d5e_7a11));
        for (int c = 0; c < NC; c++) begin ev[c] = 1'b0; ed[c] = '0; end
        for (int k = 0; k <= NF; k++)
            for (int p = 0; p < T; p++) cfg_mem[k][p] = '0;
        for (int k = 0; k < NF; k++) begin
            int kd;
            kd = 3;
            if (k == 0 || k == 24 || (k >= 26 && k <= 28)) kd = 0;
            if (k == 1) kd = 1;
            if (k == 2) kd = 2;
            if (k == 23) kd = 4;
            if (k == COL_FRAME) kd = 5;
            build(k, kd);
        end

        rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
        cfg_we = 1'b0; cfg_slot = '0; cfg_sel = '0;
        repeat (3) @(negedge clk);
        #5;
        check(out_valid == 1'b0, "R8 reset out_valid", int'(out_valid), 0);
        check(collision == 1'b0, "R8 reset collision", int'(collision), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int c = 0; c < NC; c++) begin
            int k, p;
            bit skip;
            k = c / T;
            p = c % T;
            in_valid = (k < NF) ? fv[k][p] : 1'b0;
            in_data  = (k < NF) ? fd[k][p] : '0;
            cfg_we   = (k + 1 < NF);
            cfg_slot = 4'(p);
            cfg_sel  = (k + 1 < NF) ? cfg_mem[k+1][p] : '0;
            #5;
            if (in_valid)  n_in++;
            if (out_valid) n_out++;
            skip = (c >= COL_FRAME * T) && (c < (COL_FRAME + 4) * T);
            if (!skip) begin
                check(out_valid == ev[c], tag_of(c), int'(out_valid), int'(ev[c]));
                if (ev[c] && out_valid)
                    check(out_data == ed[c], tag_of(c), int'(out_data), int'(ed[c]));
                check(collision == 1'b0, "R7 no collision", int'(collision), 0);
            end
            if (c == COL_FRAME * T)
                check(collision == 1'b0, "R7 before clash", int'(collision), 0);
            if (c == COL_FRAME * T + 1) begin
                check(collision == 1'b1, "R7 clash flagged", int'(collision), 1);
                check(out_valid == 1'b0, "R7 clash not yet at output", int'(out_valid), 0);
            end
            if (c < NC - 1) @(negedge clk);
        end
        check(n_out <= n_in, "R9 word count", n_out, n_in);
        report();
    end

endmodule